// File: doc/BRIEF.md
# Register Window State Tracker

This block holds the bookkeeping state for a counter-managed register window file in a 64-bit windowed processor. Four small counters (windows free to save into, windows that can be restored, windows known to be clean, and windows owned by another address space), a six-bit window-state field and the current window pointer live here. A pipeline issues one window command per cycle: save, restore, flush, saved or restored. The block either commits the command by updating its counters and pointer, or refuses it and reports a trap type code for the vector logic to dispatch.

The pointer is kept internally in descending order. The architectural view that software reads and writes counts the other way, as the window count minus one minus the internal pointer. A load port lets privileged software set any counter, the window-state field or the architectural pointer. The load port takes precedence over a command in the same cycle.

All state is registered. A committed command is visible on the outputs one cycle after it is presented. A trap shows up as a one-cycle strobe in that same cycle and leaves every counter and the pointer untouched.

Top module: `win_tracker`

## Requirements
- R1: Save (cmd_op 0) with can-save nonzero and clean-window different from can-restore decrements can-save, increments can-restore and moves the internal pointer down by one, from 0 to NWIN-1.
- R2: Save with can-save equal to zero raises a spill trap.
- R3: Save with can-save nonzero and clean-window equal to can-restore raises a clean-window trap of type 0x024.
- R4: Restore (cmd_op 1) with can-restore zero raises a fill trap. Otherwise it increments can-save, decrements can-restore and moves the pointer up by one, from NWIN-1 to 0.
- R5: A spill trap type is 0x080 and a fill trap type is 0x0C0, ORed with a variant. When other-window is nonzero, the variant is 0x020 plus window-state bits 5:3 placed in bits 4:2. When other-window is zero, the variant is window-state bits 2:0 placed in bits 4:2.
- R6: Flush (cmd_op 2) raises a spill trap, encoded as in R5, exactly when can-save differs from NWIN-2. Otherwise nothing changes.
- R7: Saved (cmd_op 3) increments can-save. It also decrements other-window when that is nonzero, and decrements can-restore when other-window is zero.
- R8: Restored (cmd_op 4) increments can-restore. It increments clean-window only while clean-window is below NWIN-1. It also decrements other-window when that is nonzero, and decrements can-save when other-window is zero.
- R9: arch_cwp always reads NWIN-1 minus the internal pointer.
- R10: A pointer load (wr_sel 5) reduces wr_data modulo NWIN, then sets the internal pointer so that arch_cwp equals the reduced value.
- R11: A trap leaves all counters and the pointer unchanged. trap_valid is high for exactly the cycle after the refused command, with trap_type valid in that cycle.
- R12: The load port writes can-save (wr_sel 0), can-restore (1), clean-window (2), other-window (3) or window-state (4) from wr_data. A command presented in the same cycle as a load is ignored.
- R13: After reset, can-save is NWIN-2, can-restore is 0, clean-window is NWIN-1, other-window is 0, window-state is 0, the internal pointer is 0 and trap_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A window command is presented |
| cmd_op | input | 3 | Command code: 0 save, 1 restore, 2 flush, 3 saved, 4 restored |
| wr_en | input | 1 | Load port strobe |
| wr_sel | input | 3 | Load target: 0 can-save, 1 can-restore, 2 clean-window, 3 other-window, 4 window-state, 5 architectural pointer |
| wr_data | input | DW | Load value |
| cansave | output | CW | Can-save counter |
| canrestore | output | CW | Can-restore counter |
| cleanwin | output | CW | Clean-window counter |
| otherwin | output | CW | Other-window counter |
| wstate | output | 6 | Window-state field |
| cwp | output | CW | Internal window pointer |
| arch_cwp | output | CW | Architectural window pointer view |
| trap_valid | output | 1 | One-cycle trap strobe |
| trap_type | output | TTW | Trap type code |

## Verification
The hardest situation to reach is the other-window variant of the trap codes. Other-window never becomes nonzero through commands from reset, so the bench uses the load port to set it and to put distinct patterns in the two halves of the window-state field. A wrong half then gives a different code. The clean-window trap needs can-save nonzero while clean-window equals can-restore, which the reset values never produce, so the bench loads all three counters before the save. Wrap of the pointer in both directions is reached by a save from pointer 0, and by a restore after an architectural load has set the internal pointer to NWIN-1.

// File: rtl/win_pkg.sv
package win_pkg;

   typedef enum logic [2:0] {
      OP_SAVE     = 3'd0,
      OP_RESTORE  = 3'd1,
      OP_FLUSH    = 3'd2,
      OP_SAVED    = 3'd3,
      OP_RESTORED = 3'd4
   } win_op_e;

   typedef enum logic [2:0] {
      SEL_CANSAVE = 3'd0,
      SEL_CANREST = 3'd1,
      SEL_CLEAN   = 3'd2,
      SEL_OTHER   = 3'd3,
      SEL_WSTATE  = 3'd4,
      SEL_PTR     = 3'd5
   } win_sel_e;

   localparam int WSW = 6;

endpackage

// File: rtl/win_trapcode.sv
module win_trapcode
   import win_pkg::*;
#(
   parameter int TTW        = 9,
   parameter int SPILL_BASE = 'h080,
   parameter int FILL_BASE  = 'h0C0,
   parameter int CLEAN_CODE = 'h024,
   parameter int OTHER_FLAG = 'h020
) (
   input  logic [WSW-1:0] wstate,
   input  logic           other_nz,
   input  logic           is_fill,
   input  logic           is_clean,
   output logic [TTW-1:0] tt
);

   logic [TTW-1:0] variant;
   logic [TTW-1:0] base;

   always_comb begin
      variant = '0;
      if (other_nz) begin
         variant      = TTW'(OTHER_FLAG);
         variant[4:2] = wstate[5:3];
      end else begin
         variant[4:2] = wstate[2:0];
      end
      base = is_fill ? TTW'(FILL_BASE) : TTW'(SPILL_BASE);
      tt   = is_clean ? TTW'(CLEAN_CODE) : (base | variant);
   end

endmodule

// File: rtl/win_ptr.sv
module win_ptr #(
   parameter int NWIN = 8,
   parameter int DW   = 8,
   localparam int CW  = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_dn,
   input  logic          step_up,
   input  logic          ld,
   input  logic [DW-1:0] ld_data,
   output logic [CW-1:0] cwp,
   output logic [CW-1:0] arch_cwp
);

   localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

   logic [CW-1:0] ptr_q;
   logic [CW-1:0] dn_nxt;
   logic [CW-1:0] up_nxt;
   logic [DW-1:0] red;

   generate
      if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
         assign dn_nxt = ptr_q - 1'b1;
         assign up_nxt = ptr_q + 1'b1;
      end else begin : g_cmp
         assign dn_nxt = (ptr_q == '0)  ? TOP : ptr_q - 1'b1;
         assign up_nxt = (ptr_q == TOP) ? '0  : ptr_q + 1'b1;
      end
   endgenerate

   assign red = ld_data % DW'(NWIN);

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (ld)      ptr_q <= TOP - red[CW-1:0];
      else if (step_dn) ptr_q <= dn_nxt;
      else if (step_up) ptr_q <= up_nxt;
   end

   assign cwp      = ptr_q;
   assign arch_cwp = TOP - ptr_q;

endmodule

// File: rtl/win_counters.sv
module win_counters
   import win_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int DW   = 8,
   localparam int CW  = $clog2(NWIN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           save_go,
   input  logic           restore_go,
   input  logic           saved_go,
   input  logic           restored_go,
   input  logic           ld_en,
   input  logic [2:0]     ld_sel,
   input  logic [DW-1:0]  ld_data,
   output logic [CW-1:0]  cansave,
   output logic [CW-1:0]  canrestore,
   output logic [CW-1:0]  cleanwin,
   output logic [CW-1:0]  otherwin,
   output logic [WSW-1:0] wstate
);

   localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

   logic [CW-1:0]  cs_q, cr_q, cw_q, ow_q;
   logic [WSW-1:0] ws_q;
   logic           ow_nz;

   assign ow_nz = (ow_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= CW'(NWIN - 2);
         cr_q <= '0;
         cw_q <= TOP;
         ow_q <= '0;
         ws_q <= '0;
      end else if (ld_en) begin
         case (win_sel_e'(ld_sel))
            SEL_CANSAVE: cs_q <= ld_data[CW-1:0];
            SEL_CANREST: cr_q <= ld_data[CW-1:0];
            SEL_CLEAN:   cw_q <= ld_data[CW-1:0];
            SEL_OTHER:   ow_q <= ld_data[CW-1:0];
            SEL_WSTATE:  ws_q <= ld_data[WSW-1:0];
            default:     ;
         endcase
      end else if (save_go) begin
         cs_q <= cs_q - 1'b1;
         cr_q <= cr_q + 1'b1;
      end else if (restore_go) begin
         cs_q <= cs_q + 1'b1;
         cr_q <= cr_q - 1'b1;
      end else if (saved_go) begin
         cs_q <= cs_q + 1'b1;
         if (ow_nz) ow_q <= ow_q - 1'b1;
         else       cr_q <= cr_q - 1'b1;
      end else if (restored_go) begin
         cr_q <= cr_q + 1'b1;
         if (cw_q < TOP) cw_q <= cw_q + 1'b1;
         if (ow_nz) ow_q <= ow_q - 1'b1;
         else       cs_q <= cs_q - 1'b1;
      end
   end

   assign cansave    = cs_q;
   assign canrestore = cr_q;
   assign cleanwin   = cw_q;
   assign otherwin   = ow_q;
   assign wstate     = ws_q;

endmodule

// File: rtl/win_tracker.sv
module win_tracker
   import win_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int DW   = 8,
   parameter int TTW  = 9,
   localparam int CW  = $clog2(NWIN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [2:0]     cmd_op,
   input  logic           wr_en,
   input  logic [2:0]     wr_sel,
   input  logic [DW-1:0]  wr_data,
   output logic [CW-1:0]  cansave,
   output logic [CW-1:0]  canrestore,
   output logic [CW-1:0]  cleanwin,
   output logic [CW-1:0]  otherwin,
   output logic [5:0]     wstate,
   output logic [CW-1:0]  cwp,
   output logic [CW-1:0]  arch_cwp,
   output logic           trap_valid,
   output logic [TTW-1:0] trap_type
);

   generate
      if (NWIN < 3) begin : g_bad_nwin
         $error("win_tracker: NWIN must be at least 3");
      end
      if (DW < WSW || DW < CW) begin : g_bad_dw
         $error("win_tracker: DW too narrow for the loaded fields");
      end
      if (TTW < 8) begin : g_bad_ttw
         $error("win_tracker: TTW must be at least 8");
      end
   endgenerate

   localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);

   logic           go;
   logic           save_go, restore_go, saved_go, restored_go;
   logic           trap_now, is_fill, is_clean;
   logic [TTW-1:0] tt;
   logic           trap_q;
   logic [TTW-1:0] tt_q;

   assign go = cmd_valid && !wr_en;

   always_comb begin
      save_go     = 1'b0;
      restore_go  = 1'b0;
      saved_go    = 1'b0;
      restored_go = 1'b0;
      trap_now    = 1'b0;
      is_fill     = 1'b0;
      is_clean    = 1'b0;
      if (go) begin
         case (win_op_e'(cmd_op))
            OP_SAVE: begin
               if (cansave == '0) begin
                  trap_now = 1'b1;
               end else if (cleanwin == canrestore) begin
                  trap_now = 1'b1;
                  is_clean = 1'b1;
               end else begin
                  save_go = 1'b1;
               end
            end
            OP_RESTORE: begin
               if (canrestore == '0) begin
                  trap_now = 1'b1;
                  is_fill  = 1'b1;
               end else begin
                  restore_go = 1'b1;
               end
            end
            OP_FLUSH:    trap_now    = (cansave != FLUSH_OK);
            OP_SAVED:    saved_go    = 1'b1;
            OP_RESTORED: restored_go = 1'b1;
            default:     ;
         endcase
      end
   end

   win_counters #(.NWIN(NWIN), .DW(DW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_go    (save_go),
      .restore_go (restore_go),
      .saved_go   (saved_go),
      .restored_go(restored_go),
      .ld_en      (wr_en),
      .ld_sel     (wr_sel),
      .ld_data    (wr_data),
      .cansave    (cansave),
      .canrestore (canrestore),
      .cleanwin   (cleanwin),
      .otherwin   (otherwin),
      .wstate     (wstate)
   );

   win_ptr #(.NWIN(NWIN), .DW(DW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_dn (save_go),
      .step_up (restore_go),
      .ld      (wr_en && (wr_sel == SEL_PTR)),
      .ld_data (wr_data),
      .cwp     (cwp),
      .arch_cwp(arch_cwp)
   );

   win_trapcode #(.TTW(TTW)) u_tt (
      .wstate  (wstate),
      .other_nz(otherwin != '0),
      .is_fill (is_fill),
      .is_clean(is_clean),
      .tt      (tt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_q <= 1'b0;
         tt_q   <= '0;
      end else begin
         trap_q <= trap_now;
         if (trap_now) tt_q <= tt;
      end
   end

   assign trap_valid = trap_q;
   assign trap_type  = tt_q;

endmodule

// File: rtl/win_tracker_chk.sv
module win_tracker_chk #(
   parameter int NWIN = 8,
   parameter int DW   = 8,
   parameter int TTW  = 9,
   localparam int CW  = $clog2(NWIN)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cmd_valid,
   input logic [2:0]     cmd_op,
   input logic           wr_en,
   input logic [2:0]     wr_sel,
   input logic [DW-1:0]  wr_data,
   input logic [CW-1:0]  cansave,
   input logic [CW-1:0]  canrestore,
   input logic [CW-1:0]  cleanwin,
   input logic [CW-1:0]  cwp,
   input logic [CW-1:0]  arch_cwp,
   input logic           trap_valid,
   input logic [TTW-1:0] trap_type
);

   // R1
   save_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !wr_en && cmd_op == 3'd0 && cansave != '0 && cleanwin != canrestore)
      |=> (cansave == CW'($past(cansave) - 1'b1)) && (canrestore == CW'($past(canrestore) + 1'b1))
          && (int'(cwp) == (($past(cwp) == '0) ? NWIN - 1 : int'($past(cwp)) - 1)) && !trap_valid);

   // R4
   fill_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !wr_en && cmd_op == 3'd1 && canrestore == '0)
      |=> trap_valid && ((trap_type & TTW'('h0C0)) == TTW'('h0C0)));

   // R11
   trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $stable(cansave) && $stable(canrestore) && $stable(cleanwin) && $stable(cwp));

   // R10
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd5) |=> (int'(arch_cwp) == int'($past(wr_data)) % NWIN));

   // R12
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != 3'd5) |=> $stable(cwp) && !trap_valid);

   // R9
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cwp) < NWIN) && (int'(arch_cwp) < NWIN));

endmodule

bind win_tracker win_tracker_chk #(.NWIN(NWIN), .DW(DW), .TTW(TTW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .cansave   (cansave),
   .canrestore(canrestore),
   .cleanwin  (cleanwin),
   .cwp       (cwp),
   .arch_cwp  (arch_cwp),
   .trap_valid(trap_valid),
   .trap_type (trap_type)
);

// File: tb/test_win_tracker.sv
module test_win_tracker;

   localparam int NWIN = 8;
   localparam int DW   = 8;
   localparam int TTW  = 9;
   localparam int CW   = $clog2(NWIN);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0;
   logic [2:0]     cmd_op = '0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_sel = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [CW-1:0]  cansave, canrestore, cleanwin, otherwin, cwp, arch_cwp;
   logic [5:0]     wstate;
   logic           trap_valid;
   logic [TTW-1:0] trap_type;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   win_tracker #(.NWIN(NWIN), .DW(DW), .TTW(TTW)) i_win_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cansave(cansave), .canrestore(canrestore), .cleanwin(cleanwin),
      .otherwin(otherwin), .wstate(wstate), .cwp(cwp), .arch_cwp(arch_cwp),
      .trap_valid(trap_valid), .trap_type(trap_type)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic op(input int code);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'(code);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wr(input int sel, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = 3'(sel);
      wr_data = DW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic state(input string tag, input int cs, input int cr, input int p);
      chk({tag, " cansave"},    int'(cansave),    cs);
      chk({tag, " canrestore"}, int'(canrestore), cr);
      chk({tag, " cwp"},        int'(cwp),        p);
   endtask

   task automatic t_reset();
      state("R13 reset", NWIN - 2, 0, 0);
      chk("R13 reset cleanwin", int'(cleanwin), NWIN - 1);
      chk("R13 reset otherwin", int'(otherwin), 0);
      chk("R13 reset wstate", int'(wstate), 0);
      chk("R13 reset trap", int'(trap_valid), 0);
      chk("R9 reset arch", int'(arch_cwp), NWIN - 1);
   endtask

   task automatic t_save_restore();
      op(0);
      state("R1 save", 5, 1, 7);
      chk("R1 save trap", int'(trap_valid), 0);
      chk("R9 arch after save", int'(arch_cwp), 0);
      op(1);
      state("R4 restore", 6, 0, 0);
      chk("R9 arch after restore", int'(arch_cwp), 7);
   endtask

   task automatic t_fill();
      op(1);
      chk("R4 fill valid", int'(trap_valid), 1);
      chk("R5 fill plain", int'(trap_type), 'h0C0);
      state("R11 fill hold", 6, 0, 0);
      idle();
      chk("R11 strobe drops", int'(trap_valid), 0);
      wr(4, 'h2B);
      chk("R12 wstate load", int'(wstate), 'h2B);
      op(1);
      chk("R5 fill normal variant", int'(trap_type), 'h0CC);
      wr(3, 2);
      op(1);
      chk("R5 fill other variant", int'(trap_type), 'h0F4);
   endtask

   task automatic t_spill();
      wr(0, 0);
      op(0);
      chk("R2 spill valid", int'(trap_valid), 1);
      chk("R5 spill other variant", int'(trap_type), 'h0B4);
      state("R11 spill hold", 0, 0, 0);
      wr(3, 0);
      op(0);
      chk("R5 spill normal variant", int'(trap_type), 'h08C);
   endtask

   task automatic t_clean();
      wr(0, 3);
      wr(1, 2);
      wr(2, 2);
      op(0);
      chk("R3 clean valid", int'(trap_valid), 1);
      chk("R3 clean code", int'(trap_type), 'h024);
      state("R11 clean hold", 3, 2, 0);
      wr(2, 4);
      op(0);
      state("R3 save after clean", 2, 3, 7);
      chk("R3 no trap", int'(trap_valid), 0);
   endtask

   task automatic t_flush();
      op(2);
      chk("R6 flush trap", int'(trap_valid), 1);
      chk("R6 flush code", int'(trap_type), 'h08C);
      state("R6 flush hold", 2, 3, 7);
      wr(0, NWIN - 2);
      op(2);
      chk("R6 flush quiet", int'(trap_valid), 0);
      state("R6 flush quiet state", 6, 3, 7);
   endtask

   task automatic t_saved();
      op(3);
      state("R7 saved ow0", 7, 2, 7);
      wr(3, 3);
      wr(0, 1);
      op(3);
      state("R7 saved ow", 2, 2, 7);
      chk("R7 saved ow dec", int'(otherwin), 2);
   endtask

   task automatic t_restored();
      op(4);
      state("R8 restored ow", 2, 3, 7);
      chk("R8 clean inc", int'(cleanwin), 5);
      chk("R8 ow dec", int'(otherwin), 1);
      wr(3, 0);
      wr(2, NWIN - 1);
      op(4);
      state("R8 restored ow0", 1, 4, 7);
      chk("R8 clean saturate", int'(cleanwin), NWIN - 1);
   endtask

   task automatic t_ptr();
      wr(5, 2);
      chk("R10 arch load", int'(arch_cwp), 2);
      chk("R10 internal", int'(cwp), 5);
      wr(5, 11);
      chk("R10 modulo arch", int'(arch_cwp), 3);
      chk("R10 modulo internal", int'(cwp), 4);
      wr(5, 8);
      chk("R10 modulo top", int'(cwp), 7);
      op(1);
      state("R4 restore wrap", 2, 3, 0);
      chk("R9 arch wrap", int'(arch_cwp), 7);
   endtask

   task automatic t_prio();
      @(negedge clk);
      wr_en     = 1'b1;
      wr_sel    = 3'd0;
      wr_data   = 8'd5;
      cmd_valid = 1'b1;
      cmd_op    = 3'd0;
      @(negedge clk);
      wr_en     = 1'b0;
      cmd_valid = 1'b0;
      state("R12 load over save", 5, 3, 0);
      chk("R12 no trap", int'(trap_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_save_restore();
      t_fill();
      t_spill();
      t_clean();
      t_flush();
      t_saved();
      t_restored();
      t_ptr();
      t_prio();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule